// File: doc/BRIEF.md
# HDLC Receiver with Address Filtering

This block takes a serial bit stream, one bit per cycle in which `bit_en` is high, and recovers HDLC frames from it. It looks for the flag pattern at every bit position. It deletes the zeros that the transmitter inserted after runs of five ones. It recognises aborts and idle line conditions, and it checks each frame against the 16-bit CCITT frame check sequence. Frames whose leading address byte or bytes do not match the programmed filter are dropped without producing any output. For accepted frames, the payload bytes appear on a byte port. The first byte carries a start marker. After the last byte comes a separate end pulse that carries a two-bit status.

The `bit_en` input sets the line rate. It can be pulsed at either of two D-channel rates, or at any other rate, with no change to the logic. Asserting `bypass` turns off all protocol handling: every enabled bit is packed into bytes, least significant bit first, and delivered as is.

Top module: `hdlc_rx_filter`

## Requirements
- R1: A flag (01111110, sent LSB first) is found at any bit offset. Flags are never delivered as data. For an accepted frame, every payload byte is delivered in order with `out_valid`, and `out_sof` is high only on the first. The two check bytes are withheld. One `out_eof` pulse, with `out_valid` low, follows the last payload byte once the closing flag arrives.
- R2: Inside a frame, a 0 that follows five consecutive 1s is discarded, and the bits around it are joined into bytes as if it were absent.
- R3: A frame of at least four bytes between flags ends with `out_status` = 0 (good) when the check register, preset to 0xFFFF and updated LSB first with x^16+x^12+x^5+1, holds 0xF0B8 after the last byte. Otherwise it ends with `out_status` = 1 (check error).
- R4: Seven consecutive 1s abort the current frame. If the frame had already delivered bytes, an `out_eof` pulse with `out_status` = 2 follows. Nothing more comes from that frame, and the receiver waits for the next flag.
- R5: A frame with exactly three bytes between flags delivers its first byte and ends with `out_status` = 3 (too short). A frame with two or fewer bytes produces no output at all.
- R6: With `addr_mode` = 1, a frame is delivered only if its first byte equals `addr_first`.
- R7: With `addr_mode` = 2 or 3, a frame is delivered only if its first byte equals `addr_first` and its second byte equals `addr_second`.
- R8: When `allcall_en` is high, a first byte of 0xFF (in one-byte mode), or first and second bytes of 0xFF (in two-byte mode), are accepted whatever the programmed addresses are. When `allcall_en` is low, they get no special treatment.
- R9: With `addr_mode` = 0, every frame is delivered.
- R10: While `bypass` is high, each group of eight enabled bits is delivered as one byte (the first bit becomes bit 0), with no flag search, zero deletion, `out_sof` or `out_eof`.
- R11: Cycles with `bit_en` low have no effect, whatever value `rx_bit` holds.
- R12: `idle` goes high once fifteen or more consecutive 1s have been received, and it returns low at the next 0.
- R13: While `rst` is high, `out_valid`, `out_sof`, `out_eof` and `idle` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `rx_bit` in this cycle |
| rx_bit | input | 1 | Serial line bit |
| bypass | input | 1 | Raw byte packing, no protocol handling |
| addr_mode | input | 2 | 0 any, 1 one-byte, 2/3 two-byte address |
| allcall_en | input | 1 | Accept the all-ones address |
| addr_first | input | 8 | Expected first address byte |
| addr_second | input | 8 | Expected second address byte |
| out_valid | output | 1 | Data byte on `out_data` |
| out_data | output | 8 | Delivered byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Frame end pulse, status valid |
| out_status | output | 2 | 0 good, 1 check error, 2 aborted, 3 too short |
| idle | output | 1 | Line idle (15+ ones) |

## Verification
The hardest condition to create is a zero-deletion point that falls across a byte boundary, in the same frame as a closing flag whose run of ones is only one bit longer than a stuffing run. Random payloads alone seldom produce this. Directed frames therefore contain back-to-back 0xFF and 0x7E bytes, so that inserted zeros land at several bit offsets. The random phase adds irregular gaps in `bit_en`, with noise on `rx_bit` during those gaps, so the delineation logic is also exercised when qualified bits are far apart.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int BYTE_W    = 8;
    localparam int CRC_W     = 16;
    localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h8408;  // reflected x^16+x^12+x^5+1
    localparam logic [CRC_W-1:0] CRC_GOOD = 16'hF0B8;
    localparam int RUN_STUFF = 5;
    localparam int RUN_FLAG  = 6;
    localparam logic [BYTE_W-1:0] ALL_CALL = 8'hFF;

    typedef enum logic [1:0] {
        ST_GOOD    = 2'd0,
        ST_BAD_FCS = 2'd1,
        ST_ABORT   = 2'd2,
        ST_SHORT   = 2'd3
    } rx_status_e;

    // Per-bit event produced by the delineator
    typedef struct packed {
        logic data;   // bit belongs to the byte stream
        logic value;  // its value
        logic flag;   // flag just completed
        logic abort;  // seventh consecutive one
    } bit_ev_t;

    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0] crc_in,
        input logic [BYTE_W-1:0] din
    );
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int i = 0; i < BYTE_W; i++) begin
            if (c[0] ^ din[i]) c = (c >> 1) ^ CRC_POLY;
            else               c = c >> 1;
        end
        return c;
    endfunction

    function automatic logic addr_ok(
        input logic [1:0]        mode,
        input logic              allc,
        input logic [BYTE_W-1:0] a1,
        input logic [BYTE_W-1:0] a2,
        input logic [BYTE_W-1:0] b0,
        input logic [BYTE_W-1:0] b1
    );
        if (mode == 2'd0) return 1'b1;
        if (mode == 2'd1) return (b0 == a1) || (allc && (b0 == ALL_CALL));
        return ((b0 == a1) && (b1 == a2)) ||
               (allc && (b0 == ALL_CALL) && (b1 == ALL_CALL));
    endfunction

endpackage

// File: rtl/hdlc_rx_delin.sv
module hdlc_rx_delin
    import hdlc_rx_pkg::*;
#(
    parameter int IDLE_RUN = 15
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_en,
    input  logic    rx_bit,
    input  logic    bypass,
    output bit_ev_t ev,
    output logic    idle
);
    localparam int RUN_W = $clog2(IDLE_RUN + 1);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (bit_en) begin
            if (!rx_bit)                           run_q <= '0;
            else if (run_q != RUN_W'(IDLE_RUN))    run_q <= run_q + 1'b1;
        end
    end

    always_comb begin
        ev = '0;
        if (bit_en) begin
            ev.value = rx_bit;
            if (bypass) begin
                ev.data = 1'b1;
            end else if (rx_bit) begin
                ev.data  = (run_q < RUN_W'(RUN_STUFF));
                ev.abort = (run_q == RUN_W'(RUN_FLAG));
            end else begin
                ev.data  = (run_q < RUN_W'(RUN_STUFF));
                ev.flag  = (run_q == RUN_W'(RUN_FLAG));
            end
        end
    end

    assign idle = (run_q == RUN_W'(IDLE_RUN));

endmodule

// File: rtl/hdlc_rx_pack.sv
module hdlc_rx_pack
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bit_ev_t           ev,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_dat,
    output logic              flag_p,
    output logic              abort_p
);
    localparam int BIT_W = $clog2(BYTE_W);

    logic [BIT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] sh_n;

    assign sh_n = {ev.value, sh_q[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            sh_q     <= '0;
            byte_vld <= 1'b0;
            byte_dat <= '0;
            flag_p   <= 1'b0;
            abort_p  <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            flag_p   <= ev.flag;
            abort_p  <= ev.abort;
            if (ev.flag || ev.abort) begin
                cnt_q <= '0;
            end else if (ev.data) begin
                sh_q  <= sh_n;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == BIT_W'(BYTE_W - 1)) begin
                    byte_vld <= 1'b1;
                    byte_dat <= sh_n;
                end
            end
        end
    end

    // A flag bit is never a data bit, so no byte completes with it
    assert_flag_not_byte_R1: assert property (@(posedge clk) disable iff (rst)
        flag_p |-> !byte_vld);

endmodule

// File: rtl/hdlc_rx_frame.sv
module hdlc_rx_frame
    import hdlc_rx_pkg::*;
#(
    parameter int MIN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bypass,
    input  logic [1:0]        addr_mode,
    input  logic              allcall_en,
    input  logic [BYTE_W-1:0] addr_first,
    input  logic [BYTE_W-1:0] addr_second,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_dat,
    input  logic              flag_p,
    input  logic              abort_p,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic [1:0]        out_status
);
    localparam int CNT_W = $clog2(MIN_BYTES + 1);

    logic              in_frame_q;
    logic              sent_q;
    logic              accept_q;
    logic [CNT_W-1:0]  nb_q;
    logic [CRC_W-1:0]  crc_q;
    logic [BYTE_W-1:0] p0_q, p1_q;   // p1 is the older byte
    logic              acc_now;
    logic              third_byte;
    rx_status_e        end_st;

    assign third_byte = (nb_q == CNT_W'(2));
    assign acc_now    = third_byte ?
        addr_ok(addr_mode, allcall_en, addr_first, addr_second, p1_q, p0_q) : accept_q;

    always_comb begin
        if (nb_q < CNT_W'(MIN_BYTES)) end_st = ST_SHORT;
        else if (crc_q == CRC_GOOD)   end_st = ST_GOOD;
        else                          end_st = ST_BAD_FCS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            sent_q     <= 1'b0;
            accept_q   <= 1'b0;
            nb_q       <= '0;
            crc_q      <= CRC_INIT;
            p0_q       <= '0;
            p1_q       <= '0;
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_sof    <= 1'b0;
            out_eof    <= 1'b0;
            out_status <= ST_GOOD;
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            if (bypass) begin
                in_frame_q <= 1'b0;
                sent_q     <= 1'b0;
                if (byte_vld) begin
                    out_valid <= 1'b1;
                    out_data  <= byte_dat;
                end
            end else if (abort_p) begin
                if (in_frame_q && sent_q) begin
                    out_eof    <= 1'b1;
                    out_status <= ST_ABORT;
                end
                in_frame_q <= 1'b0;
                sent_q     <= 1'b0;
            end else if (flag_p) begin
                if (in_frame_q && sent_q) begin
                    out_eof    <= 1'b1;
                    out_status <= end_st;
                end
                in_frame_q <= 1'b1;
                sent_q     <= 1'b0;
                accept_q   <= 1'b0;
                nb_q       <= '0;
                crc_q      <= CRC_INIT;
            end else if (byte_vld && in_frame_q) begin
                crc_q <= crc_step_byte(crc_q, byte_dat);
                p0_q  <= byte_dat;
                p1_q  <= p0_q;
                if (nb_q != CNT_W'(MIN_BYTES)) nb_q <= nb_q + 1'b1;
                if (nb_q >= CNT_W'(2)) begin
                    if (third_byte) accept_q <= acc_now;
                    if (acc_now) begin
                        out_valid <= 1'b1;
                        out_data  <= p1_q;
                        out_sof   <= third_byte;
                        sent_q    <= 1'b1;
                    end
                end
            end
        end
    end

    assert_sof_has_byte_R1: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);

    assert_eof_alone_R1: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> !out_valid);

    assert_bypass_unframed_R10: assert property (@(posedge clk) disable iff (rst)
        $past(bypass) |-> (!out_sof && !out_eof));

    assert_abort_ends_frame_R4: assert property (@(posedge clk) disable iff (rst)
        (abort_p && !bypass) |=> !in_frame_q);

endmodule

// File: rtl/hdlc_rx_filter.sv
module hdlc_rx_filter
    import hdlc_rx_pkg::*;
#(
    parameter int IDLE_RUN  = 15,
    parameter int MIN_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       rx_bit,
    input  logic       bypass,
    input  logic [1:0] addr_mode,
    input  logic       allcall_en,
    input  logic [7:0] addr_first,
    input  logic [7:0] addr_second,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof,
    output logic [1:0] out_status,
    output logic       idle
);
    bit_ev_t           ev;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_dat;
    logic              flag_p;
    logic              abort_p;

    hdlc_rx_delin #(.IDLE_RUN(IDLE_RUN)) u_delin (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .rx_bit (rx_bit),
        .bypass (bypass),
        .ev     (ev),
        .idle   (idle)
    );

    hdlc_rx_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .byte_vld (byte_vld),
        .byte_dat (byte_dat),
        .flag_p   (flag_p),
        .abort_p  (abort_p)
    );

    hdlc_rx_frame #(.MIN_BYTES(MIN_BYTES)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .bypass      (bypass),
        .addr_mode   (addr_mode),
        .allcall_en  (allcall_en),
        .addr_first  (addr_first),
        .addr_second (addr_second),
        .byte_vld    (byte_vld),
        .byte_dat    (byte_dat),
        .flag_p      (flag_p),
        .abort_p     (abort_p),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_sof     (out_sof),
        .out_eof     (out_eof),
        .out_status  (out_status)
    );

    assert_idle_no_sof_R12: assert property (@(posedge clk) disable iff (rst)
        (idle && !bypass) |-> !out_sof);

endmodule

// File: tb/hdlc_rx_filter_test.sv
`timescale 1ns/1ps
module hdlc_rx_filter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b0;
    logic       bypass = 1'b0;
    logic [1:0] addr_mode = 2'd0;
    logic       allcall_en = 1'b0;
    logic [7:0] addr_first = 8'h00;
    logic [7:0] addr_second = 8'h00;
    logic       out_valid, out_sof, out_eof, idle;
    logic [7:0] out_data;
    logic [1:0] out_status;

    always #10 clk = ~clk;

    hdlc_rx_filter uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .bypass(bypass),
        .addr_mode(addr_mode), .allcall_en(allcall_en), .addr_first(addr_first),
        .addr_second(addr_second), .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .out_status(out_status), .idle(idle)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit gaps_on = 1'b0;
    int tx_ones = 0;

    logic [7:0] cap_data[$];
    bit         cap_sof[$];
    int         cap_eof_n = 0;
    logic [1:0] cap_status = 2'd0;

    logic [7:0] pl[0:15];
    int         pl_len = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                cap_data.push_back(out_data);
                cap_sof.push_back(out_sof);
            end
            if (out_eof) begin
                cap_eof_n++;
                cap_status = out_status;
            end
        end
    end

    initial begin
        #(20ns * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] fcs_update(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb = r[0] ^ d[i];
            r = r >> 1;
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    function automatic bit bench_accept(input logic [1:0] m, input bit allc,
        input logic [7:0] a1, input logic [7:0] a2, input logic [7:0] b0, input logic [7:0] b1);
        if (m == 2'd0) return 1'b1;
        if (m == 2'd1) return (b0 == a1) || (allc && b0 == 8'hFF);
        return (b0 == a1 && b1 == a2) || (allc && b0 == 8'hFF && b1 == 8'hFF);
    endfunction

    task automatic send_bit(input logic b);
        if (gaps_on) begin
            int g;
            g = $urandom_range(0, 2);
            repeat (g) begin
                bit_en = 1'b0;
                rx_bit = 1'($urandom_range(0, 1));
                @(negedge clk);
            end
        end
        bit_en = 1'b1;
        rx_bit = b;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_raw(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic send_flag();
        send_raw(8'h7E);
        tx_ones = 0;
    endtask

    task automatic send_stuffed(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            send_bit(v[i]);
            if (v[i]) tx_ones++; else tx_ones = 0;
            if (tx_ones == 5) begin
                send_bit(1'b0);
                tx_ones = 0;
            end
        end
    endtask

    task automatic clear_cap();
        cap_data.delete();
        cap_sof.delete();
        cap_eof_n = 0;
    endtask

    task automatic send_frame(input bit corrupt);
        logic [15:0] c;
        c = 16'hFFFF;
        send_flag();
        for (int i = 0; i < pl_len; i++) begin
            send_stuffed(pl[i]);
            c = fcs_update(c, pl[i]);
        end
        c = ~c;
        if (corrupt) c[0] = ~c[0];
        send_stuffed(c[7:0]);
        send_stuffed(c[15:8]);
        send_flag();
        send_flag();
        repeat (6) @(negedge clk);
    endtask

    task automatic run_frame(input string req, input bit corrupt, input bit acc);
        int exp_n;
        logic [1:0] exp_st;
        clear_cap();
        send_frame(corrupt);
        exp_n = (acc && pl_len >= 1) ? pl_len : 0;
        if (pl_len + 2 < 4) exp_st = 2'd3;
        else if (corrupt)   exp_st = 2'd1;
        else                exp_st = 2'd0;
        check(cap_data.size() == exp_n, req, "byte count", cap_data.size(), exp_n);
        for (int i = 0; i < exp_n && i < cap_data.size(); i++) begin
            check(cap_data[i] == pl[i], req, "data byte", cap_data[i], pl[i]);
            check(cap_sof[i] == (i == 0), req, "sof marker", cap_sof[i], (i == 0));
        end
        check(cap_eof_n == (exp_n > 0 ? 1 : 0), req, "eof count", cap_eof_n, (exp_n > 0 ? 1 : 0));
        if (exp_n > 0) check(cap_status == exp_st, req, "status", cap_status, exp_st);
    endtask

    task automatic set_pl3(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        pl[0] = b0; pl[1] = b1; pl[2] = b2; pl_len = 3;
    endtask

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        repeat (4) @(negedge clk);
        // R13: reset state
        check(!out_valid && !out_sof && !out_eof && !idle, "R13", "outputs in reset",
              {out_valid, out_sof, out_eof, idle}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R9 R3: accept-all mode, good frame
        addr_mode = 2'd0;
        set_pl3(8'h01, 8'h02, 8'h03);
        run_frame("R1_R9", 1'b0, 1'b1);

        // R2: payload that forces zero insertion at several offsets
        pl[0] = 8'hFF; pl[1] = 8'hFF; pl[2] = 8'h7E; pl[3] = 8'h3F; pl[4] = 8'hF8; pl_len = 5;
        run_frame("R2", 1'b0, 1'b1);

        // R3: corrupted check bytes
        set_pl3(8'hA5, 8'h5A, 8'hC3);
        run_frame("R3", 1'b1, 1'b1);

        // R5: three bytes between flags, then two
        addr_mode = 2'd1; addr_first = 8'h42;
        pl[0] = 8'h42; pl_len = 1;
        run_frame("R5", 1'b0, 1'b1);
        pl_len = 0;
        run_frame("R5", 1'b0, 1'b0);

        // R6: one-byte address
        set_pl3(8'h42, 8'h10, 8'h20);
        run_frame("R6", 1'b0, 1'b1);
        set_pl3(8'h43, 8'h10, 8'h20);
        run_frame("R6", 1'b0, 1'b0);

        // R7: two-byte address
        addr_mode = 2'd2; addr_first = 8'h12; addr_second = 8'h34;
        set_pl3(8'h12, 8'h34, 8'h99);
        run_frame("R7", 1'b0, 1'b1);
        set_pl3(8'h12, 8'h35, 8'h99);
        run_frame("R7", 1'b0, 1'b0);

        // R8: all-call handling
        addr_mode = 2'd1; allcall_en = 1'b1;
        set_pl3(8'hFF, 8'h01, 8'h02);
        run_frame("R8", 1'b0, 1'b1);
        allcall_en = 1'b0;
        run_frame("R8", 1'b0, 1'b0);
        addr_mode = 2'd3; allcall_en = 1'b1;
        set_pl3(8'hFF, 8'hFF, 8'h02);
        run_frame("R8", 1'b0, 1'b1);
        set_pl3(8'hFF, 8'h34, 8'h02);
        run_frame("R8", 1'b0, 1'b0);
        allcall_en = 1'b0;

        // R4: abort after four bytes, then recovery
        addr_mode = 2'd0;
        clear_cap();
        send_flag();
        send_stuffed(8'hA1); send_stuffed(8'hB2); send_stuffed(8'hC3); send_stuffed(8'hD4);
        send_raw(8'hFF);
        tx_ones = 0;
        repeat (6) @(negedge clk);
        check(cap_data.size() == 2, "R4", "bytes before abort", cap_data.size(), 2);
        if (cap_data.size() == 2) begin
            check(cap_data[0] == 8'hA1 && cap_data[1] == 8'hB2, "R4", "abort data",
                  {cap_data[0], cap_data[1]}, 16'hA1B2);
        end
        check(cap_eof_n == 1, "R4", "abort eof count", cap_eof_n, 1);
        check(cap_status == 2'd2, "R4", "abort status", cap_status, 2);
        set_pl3(8'h11, 8'h22, 8'h33);
        run_frame("R4", 1'b0, 1'b1);

        // R12: idle detection
        send_flag();
        for (int i = 0; i < 14; i++) send_bit(1'b1);
        check(idle == 1'b0, "R12", "idle after 14 ones", idle, 0);
        send_bit(1'b1);
        check(idle == 1'b1, "R12", "idle after 15 ones", idle, 1);
        send_bit(1'b1);
        check(idle == 1'b1, "R12", "idle after 16 ones", idle, 1);
        send_bit(1'b0);
        check(idle == 1'b0, "R12", "idle after zero", idle, 0);

        // R10: raw packing
        bypass = 1'b1;
        clear_cap();
        send_raw(8'h3C); send_raw(8'h7E); send_raw(8'hFF); send_raw(8'h00); send_raw(8'hA5);
        repeat (4) @(negedge clk);
        check(cap_data.size() == 5, "R10", "raw byte count", cap_data.size(), 5);
        if (cap_data.size() == 5) begin
            check(cap_data[0] == 8'h3C, "R10", "raw byte0", cap_data[0], 8'h3C);
            check(cap_data[1] == 8'h7E, "R10", "raw byte1", cap_data[1], 8'h7E);
            check(cap_data[2] == 8'hFF, "R10", "raw byte2", cap_data[2], 8'hFF);
            check(cap_data[4] == 8'hA5, "R10", "raw byte4", cap_data[4], 8'hA5);
            check(cap_sof[0] == 1'b0, "R10", "no sof in raw mode", cap_sof[0], 0);
        end
        check(cap_eof_n == 0, "R10", "no eof in raw mode", cap_eof_n, 0);
        bypass = 1'b0;
        @(negedge clk);

        // R11 plus R6..R9 random: gapped bit enables with noise between bits
        gaps_on = 1'b1;
        for (int k = 0; k < 30; k++) begin
            int sel;
            bit corrupt;
            bit acc;
            addr_mode   = 2'($urandom_range(0, 3));
            allcall_en  = 1'($urandom_range(0, 1));
            addr_first  = 8'($urandom);
            addr_second = 8'($urandom);
            pl_len = $urandom_range(2, 8);
            for (int i = 0; i < pl_len; i++) pl[i] = 8'($urandom);
            sel = $urandom_range(0, 3);
            if (sel == 0) begin pl[0] = addr_first; pl[1] = addr_second; end
            else if (sel == 1) begin pl[0] = 8'hFF; pl[1] = 8'hFF; end
            else if (sel == 2) pl[0] = addr_first;
            corrupt = ($urandom_range(0, 4) == 0);
            acc = bench_accept(addr_mode, allcall_en, addr_first, addr_second, pl[0], pl[1]);
            run_frame("R11", corrupt, acc);
        end
        gaps_on = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule